// File: doc/BRIEF.md
# Ping-Pong Sample Memory Readout Sequencer

This block moves captured samples from a large external sample memory to a host link, one fixed-size chunk at a time. It holds two on-chip RAM banks. One bank can be filled from the external memory while the other bank is being streamed to the host, so the fetch and the readout overlap.

The host drives a byte-wide command stream. The upper bits of a command carry an opcode, and bit 4 selects one of the two banks. A row-load command is followed by two raw bytes that set the 16-bit chunk index of the next fetch. Each fetch copies one chunk from the external memory into a bank and then moves the row counter to the next chunk. A wait command stalls the command stream until the outstanding fetch has completed. A read command streams either the whole bank or a fixed-length prefix of it.

A typical sequence runs as follows. Fetch into bank 0 and wait. Then, for each chunk, fetch into the other bank, read the current bank and wait. The fetch is left out for the last chunk.

Top module: `sample_readout_seq`

## Requirements
- R1: After reset, `cmdReady` is 1, and `outValid`, `memReq` and `memRow` are 0.
- R2: A command whose upper nibble is 0x2 makes the next two accepted bytes the new row index, taking the high byte first and then the low byte. The next fetch presents exactly this value on `memRow`.
- R3: A fetch command has bits [7:5] equal to 3'b011 (0x6x is bank 0, 0x7x is bank 1). It raises `memReq` in the cycle after acceptance, with `memRow` holding the row. `memRow` stays stable while `memReq` is high. Each cycle with `memAck` writes `memData` to the next byte of the bank. `memReq` drops after CHUNK bytes.
- R4: Each fetch advances the row counter by one, so back-to-back fetches read consecutive rows.
- R5: A wait command has upper nibble 0x5. It holds `cmdReady` low while a fetch is outstanding. With no fetch outstanding it is accepted in the cycle it is presented.
- R6: A full read has bits [7:5] equal to 3'b101 (0xAx is bank 0, 0xBx is bank 1). It emits the CHUNK bytes of the selected bank on `outData`, in address order, one byte per cycle with `outValid` high.
- R7: A short read has bits [7:5] equal to 3'b100 (0x8x is bank 0, 0x9x is bank 1). It emits only the first SHORT bytes of the selected bank.
- R8: A fetch into the bank that is being streamed is held off (`cmdReady` low) until the stream has ended, so the streamed data is the old content. A fetch into the other bank, and a read of another bank while a fetch is running, are accepted at once, so fetch and readout overlap.
- R9: A read command stalls while a stream is active. A fetch command stalls while another fetch is outstanding.
- R10: Commands with any other upper nibble (0x0, 0x1, 0x3, 0x4, 0xC to 0xF) are accepted and ignored: they cause no output bytes, no memory request and no change of the row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command byte present |
| cmdByte | input | 8 | Command or row data byte |
| cmdReady | output | 1 | Command byte taken on this edge when valid |
| memReq | output | 1 | Fetch burst outstanding |
| memRow | output | 16 | Chunk index of the current fetch |
| memAck | input | 1 | One burst byte delivered this cycle |
| memData | input | 8 | Burst byte |
| outValid | output | 1 | Host byte valid |
| outData | output | 8 | Host byte |

## Verification
A command is taken on the clock edge where `cmdValid` and `cmdReady` are both high, and `memReq` with `memRow` is visible from the cycle after that edge. The first streamed byte appears two edges after a read is accepted, because the stream-active flag and the RAM output register each add one edge. After that, one byte follows on every cycle. The bench changes its inputs on falling edges and samples the outputs there. It counts the falling edges spent waiting for `cmdReady` to measure each stall. It collects the streamed bytes into an ordered capture buffer, so the checks compare sequences and stall lengths rather than exact edges. Bank contents are predicted from the row index and byte offset that the memory model encodes into each burst byte.

// File: rtl/srs_pkg.sv
package srs_pkg;
  // strobes from control to bank datapath
  typedef struct packed {
    logic        wrEn;
    logic        wrBank;
    logic [15:0] wrAddr;
    logic        rdEn;
    logic        rdBank;
    logic [15:0] rdAddr;
  } bankCtl_t;
endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int CHUNK = 1024,
  parameter int SHORT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [7:0]  cmdByte,
  output logic        cmdReady,
  output logic        memReq,
  output logic [15:0] memRow,
  input  logic        memAck,
  output bankCtl_t    ctl
);
  localparam int AW = (CHUNK > 1) ? $clog2(CHUNK) : 1;
  localparam logic [AW-1:0] LAST_BEAT = AW'(CHUNK - 1);

  typedef enum logic [1:0] {PH_CMD, PH_HI, PH_LO} phase_e;

  phase_e      phase;
  logic [7:0]  rowHi;
  logic [15:0] rowCnt;
  logic [15:0] rowQ;
  logic        fetchBusy, fetchBank;
  logic [AW-1:0] beatCnt;
  logic        streamBusy, streamBank;
  logic [15:0] rdIdx, streamLen;

  logic isRow, isWait, isFetch, isShort, isFull, sel, accept;

  always_comb begin
    isRow   = cmdByte[7:4] == 4'h2;
    isWait  = cmdByte[7:4] == 4'h5;
    isFetch = cmdByte[7:5] == 3'b011;
    isShort = cmdByte[7:5] == 3'b100;
    isFull  = cmdByte[7:5] == 3'b101;
    sel     = cmdByte[4];
    if (phase != PH_CMD)       cmdReady = 1'b1;
    else if (isWait)           cmdReady = !fetchBusy;
    else if (isFetch)          cmdReady = !fetchBusy && !(streamBusy && streamBank == sel);
    else if (isShort || isFull) cmdReady = !streamBusy;
    else                       cmdReady = 1'b1;
    accept = cmdValid && cmdReady;
  end

  // row loading and row counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      rowHi  <= '0;
      rowCnt <= '0;
      rowQ   <= '0;
    end else if (accept) begin
      unique case (phase)
        PH_HI:   begin rowHi <= cmdByte; phase <= PH_LO; end
        PH_LO:   begin rowCnt <= {rowHi, cmdByte}; phase <= PH_CMD; end
        default: begin
          if (isRow) phase <= PH_HI;
          if (isFetch) begin
            rowQ   <= rowCnt;
            rowCnt <= rowCnt + 16'd1;
          end
        end
      endcase
    end
  end

  // fetch burst tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetchBusy <= 1'b0;
      fetchBank <= 1'b0;
      beatCnt   <= '0;
    end else if (fetchBusy) begin
      if (memAck) begin
        beatCnt <= beatCnt + 1'b1;
        if (beatCnt == LAST_BEAT) fetchBusy <= 1'b0;
      end
    end else if (accept && phase == PH_CMD && isFetch) begin
      fetchBusy <= 1'b1;
      fetchBank <= sel;
      beatCnt   <= '0;
    end
  end

  // stream address generation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streamBusy <= 1'b0;
      streamBank <= 1'b0;
      rdIdx      <= '0;
      streamLen  <= '0;
    end else if (streamBusy) begin
      rdIdx <= rdIdx + 16'd1;
      if (rdIdx == streamLen - 16'd1) streamBusy <= 1'b0;
    end else if (accept && phase == PH_CMD && (isShort || isFull)) begin
      streamBusy <= 1'b1;
      streamBank <= sel;
      rdIdx      <= '0;
      streamLen  <= isFull ? 16'(CHUNK) : 16'(SHORT);
    end
  end

  assign memReq = fetchBusy;
  assign memRow = rowQ;

  always_comb begin
    ctl        = '0;
    ctl.wrEn   = fetchBusy && memAck;
    ctl.wrBank = fetchBank;
    ctl.wrAddr = 16'(beatCnt);
    ctl.rdEn   = streamBusy;
    ctl.rdBank = streamBank;
    ctl.rdAddr = rdIdx;
  end

  // R3: row held steady through the burst
  a_r3_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && $past(memReq) |-> $stable(memRow));
  // R3: request ends only after the final beat
  a_r3_req_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(memReq) |-> $past(memAck) && $past(beatCnt) == LAST_BEAT);
  // R8: no writes into the bank currently streamed
  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wrEn |-> !(streamBusy && streamBank == fetchBank));
  // R6 / R7: stream address stays inside its length
  a_r6_stream_bound: assert property (@(posedge clk) disable iff (!rst_n)
    streamBusy |-> rdIdx < streamLen);
endmodule

// File: rtl/srs_dpath.sv
module srs_dpath
  import srs_pkg::*;
#(
  parameter int CHUNK = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  bankCtl_t   ctl,
  input  logic [7:0] memData,
  output logic       outValid,
  output logic [7:0] outData
);
  localparam int AW = (CHUNK > 1) ? $clog2(CHUNK) : 1;

  logic rdSelQ;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] ram [CHUNK];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (ctl.wrEn && ctl.wrBank == 1'(b)) ram[ctl.wrAddr[AW-1:0]] <= memData;
      if (ctl.rdEn && ctl.rdBank == 1'(b)) q <= ram[ctl.rdAddr[AW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      rdSelQ   <= 1'b0;
    end else begin
      outValid <= ctl.rdEn;
      rdSelQ   <= ctl.rdBank;
    end
  end

  assign outData = rdSelQ ? g_bank[1].q : g_bank[0].q;

  // R8: a bank is never written and read in the same cycle
  a_r8_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.wrEn && ctl.rdEn && ctl.wrBank == ctl.rdBank));
endmodule

// File: rtl/sample_readout_seq.sv
module sample_readout_seq
  import srs_pkg::*;
#(
  parameter int CHUNK = 1024,
  parameter int SHORT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [7:0]  cmdByte,
  output logic        cmdReady,
  output logic        memReq,
  output logic [15:0] memRow,
  input  logic        memAck,
  input  logic [7:0]  memData,
  output logic        outValid,
  output logic [7:0]  outData
);
  bankCtl_t ctl;

  srs_ctrl #(.CHUNK(CHUNK), .SHORT(SHORT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .cmdReady(cmdReady), .memReq(memReq), .memRow(memRow),
    .memAck(memAck), .ctl(ctl)
  );

  srs_dpath #(.CHUNK(CHUNK)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .memData(memData),
    .outValid(outValid), .outData(outData)
  );
endmodule

// File: tb/sample_readout_seq_tb.sv
module sample_readout_seq_tb;
  localparam int CHUNK = 1024;
  localparam int SHORT = 64;

  logic clk = 0, rst_n = 0;
  logic cmdValid = 0;
  logic [7:0] cmdByte = 0;
  logic cmdReady, memReq, memAck, outValid;
  logic [15:0] memRow;
  logic [7:0] memData, outData;

  int total = 0, bad = 0;
  int beatIdx = 0;
  int capCnt = 0;
  logic [7:0] cap [0:2047];
  int stall;

  sample_readout_seq #(.CHUNK(CHUNK), .SHORT(SHORT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .cmdReady(cmdReady), .memReq(memReq), .memRow(memRow),
    .memAck(memAck), .memData(memData), .outValid(outValid), .outData(outData)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] row, input int i);
    return 8'(row[7:0] * 8'd37 + 8'(i) + 8'(i >> 8) * 8'd13 + row[15:8]);
  endfunction

  // memory model: one beat per cycle while requested
  always @(posedge clk) begin
    if (memReq && memAck) beatIdx <= beatIdx + 1;
    else if (!memReq) beatIdx <= 0;
  end
  always @(negedge clk) begin
    memAck  <= memReq;
    memData <= pat(memRow, beatIdx);
  end
  initial begin memAck = 0; memData = 0; end

  // host byte collector
  always @(negedge clk) if (rst_n && outValid) begin
    if (capCnt < 2048) cap[capCnt] = outData;
    capCnt = capCnt + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk);
    cmdValid = 1; cmdByte = b; stall = 0;
    #1;
    while (!cmdReady) begin @(negedge clk); #1; stall++; end
    @(posedge clk); #1;
    cmdValid = 0;
  endtask

  task automatic setRow(input logic [15:0] r);
    sendCmd(8'h20); sendCmd(r[15:8]); sendCmd(r[7:0]);
  endtask

  task automatic waitBytes(input int n);
    for (int k = 0; k < n + 40 && capCnt < n; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic checkData(input string req, input int base, input int n, input logic [15:0] row);
    int errs = 0;
    for (int i = 0; i < n; i++) if (cap[base + i] != pat(row, i)) errs++;
    check(req, "stream data mismatches", errs, 0);
  endtask

  task automatic fetchAndCheckRow(input logic [7:0] b, input logic [15:0] row, input string req);
    sendCmd(b);
    @(negedge clk);
    check(req, "memReq after fetch", int'(memReq), 1);
    check(req, "memRow", int'(memRow), int'(row));
  endtask

  task automatic t_reset;
    check("R1", "cmdReady", int'(cmdReady), 1);
    check("R1", "outValid", int'(outValid), 0);
    check("R1", "memReq", int'(memReq), 0);
    check("R1", "memRow", int'(memRow), 0);
  endtask

  task automatic t_basic;
    setRow(16'h0010);
    fetchAndCheckRow(8'h60, 16'h0010, "R2");
    sendCmd(8'h50);
    check("R5", "wait stalled", int'(stall > 100), 1);
    check("R3", "memReq dropped after chunk", int'(memReq), 0);
    capCnt = 0;
    sendCmd(8'hA0);
    waitBytes(CHUNK);
    check("R6", "full read length", capCnt, CHUNK);
    checkData("R6", 0, CHUNK, 16'h0010);
  endtask

  task automatic t_short;
    fetchAndCheckRow(8'h70, 16'h0011, "R4");
    sendCmd(8'h50);
    capCnt = 0;
    sendCmd(8'h90);
    waitBytes(SHORT);
    repeat (20) @(negedge clk);
    check("R7", "short read length", capCnt, SHORT);
    checkData("R7", 0, SHORT, 16'h0011);
  endtask

  task automatic t_idleWait;
    sendCmd(8'h50);
    check("R5", "wait with nothing outstanding stall", stall, 0);
  endtask

  task automatic t_overlap;
    setRow(16'h0100);
    sendCmd(8'h60); sendCmd(8'h50);
    sendCmd(8'h70);
    check("R8", "fetch other bank stall", stall, 0);
    capCnt = 0;
    sendCmd(8'hA0);
    check("R8", "read during fetch stall", stall, 0);
    check("R8", "fetch still running during read", int'(memReq), 1);
    waitBytes(CHUNK);
    checkData("R8", 0, CHUNK, 16'h0100);
    sendCmd(8'h50);
    capCnt = 0;
    sendCmd(8'hB0);
    waitBytes(CHUNK);
    checkData("R6", 0, CHUNK, 16'h0101);
  endtask

  task automatic t_holdOff;
    capCnt = 0;
    sendCmd(8'hA0);
    sendCmd(8'h60);
    check("R8", "fetch into streamed bank held", int'(stall > 1000), 1);
    @(negedge clk);
    check("R8", "stream finished before fetch", capCnt, CHUNK);
    check("R4", "row after hold", int'(memRow), 16'h0102);
    checkData("R8", 0, CHUNK, 16'h0100);
    sendCmd(8'h50);
    capCnt = 0;
    sendCmd(8'h80);
    waitBytes(SHORT);
    checkData("R8", 0, SHORT, 16'h0102);
  endtask

  task automatic t_stalls;
    capCnt = 0;
    sendCmd(8'hA0);
    sendCmd(8'h90);
    check("R9", "read during stream stalled", int'(stall > 1000), 1);
    waitBytes(CHUNK + SHORT);
    check("R9", "two streams total length", capCnt, CHUNK + SHORT);
    checkData("R9", 0, CHUNK, 16'h0102);
    checkData("R9", CHUNK, SHORT, 16'h0101);
    sendCmd(8'h70);
    sendCmd(8'h60);
    check("R9", "fetch during fetch stalled", int'(stall > 100), 1);
    @(negedge clk);
    check("R4", "second queued fetch row", int'(memRow), 16'h0104);
    sendCmd(8'h50);
  endtask

  task automatic t_ignored;
    capCnt = 0;
    sendCmd(8'h30); sendCmd(8'hC0); sendCmd(8'hF5); sendCmd(8'h45); sendCmd(8'h1F);
    check("R10", "ignored command stall", stall, 0);
    repeat (20) @(negedge clk);
    check("R10", "no output bytes", capCnt, 0);
    check("R10", "no memory request", int'(memReq), 0);
    fetchAndCheckRow(8'h60, 16'h0105, "R10");
    sendCmd(8'h50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_basic();
    t_short();
    t_idleWait();
    t_overlap();
    t_holdOff();
    t_stalls();
    t_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule